// File: doc/BRIEF.md
# Write-Completion Acknowledge Poller

This block runs on the controller side of an I2C bus, right after a write to a serial EEPROM. The stop that closes the write starts the target's internal programming cycle. While that cycle runs, the target does not answer its own address. The poller finds out when the cycle has ended by probing the target again and again. Each probe is a start condition followed by the target's address byte with the direction bit cleared. If the address byte is not acknowledged, the target is treated as still busy. The poller then sends a stop and probes again. An acknowledged probe ends the wait and the poller reports completion.

The poller does not toggle the bus lines itself. It issues byte-level commands (start, write a byte and return the acknowledge bit, stop) to a separate bit-level I2C engine. It uses a valid/ready command handshake and a one-cycle response strobe. The user raises a one-cycle request. The poller samples the 7-bit target address and a bus-hold choice at that moment, and later pulses either a completion flag or a timeout flag. The timeout flag is raised once a parameterised number of probes have all been refused. With the bus-hold choice set, a successful probe leaves the bus open so that the next transfer can continue without a stop.

Top module: `ack_poll_seq`

## Requirements
- R1: After reset `busy`, `done`, `timeout` and `cmd_valid` are low and `cmd_op` is 2'b00.
- R2: A `req_start` pulse while idle samples `tgt_addr` and `hold_bus`. Each probe then issues a start command (`cmd_op`=2'b01), followed by a byte write command (`cmd_op`=2'b10) whose `cmd_byte` is {address, 1'b0}.
- R3: The first start command is presented (`cmd_valid` high) in the cycle right after the request is accepted, with no wait.
- R4: A byte response with `rsp_ack`=0 makes the poller issue a stop command (`cmd_op`=2'b11) and then a fresh start.
- R5: A byte response with `rsp_ack`=1 and `hold_bus`=0 makes the poller issue a stop. `done` then pulses for one cycle, in the cycle after the stop's response.
- R6: A byte response with `rsp_ack`=1 and `hold_bus`=1 issues no stop. `done` pulses for one cycle, in the cycle after that byte response.
- R7: When the probe number `MAX_POLLS` is refused, the poller issues a stop and then pulses `timeout` for one cycle. It returns to idle and accepts a new request afterwards.
- R8: A command that is presented but not accepted keeps `cmd_valid`, `cmd_op` and `cmd_byte` unchanged until `cmd_ready` is high.
- R9: `req_start` and a changed `tgt_addr` have no effect while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_start | input | 1 | One-cycle request to begin polling |
| tgt_addr | input | 7 | Target address, sampled on request |
| hold_bus | input | 1 | 1: leave bus open after a successful probe |
| busy | output | 1 | Polling in progress |
| done | output | 1 | One-cycle pulse: target answered |
| timeout | output | 1 | One-cycle pulse: probe limit reached |
| cmd_valid | output | 1 | Command presented to the byte engine |
| cmd_ready | input | 1 | Byte engine takes the command |
| cmd_op | output | 2 | 01 start, 10 write byte, 11 stop, 00 none |
| cmd_byte | output | 8 | Byte for a write command |
| rsp_valid | input | 1 | One-cycle strobe: command finished |
| rsp_ack | input | 1 | Acknowledge bit of a finished byte write |

## Verification
The assertions assume the byte engine follows a simple contract. It raises `rsp_valid` only for a command it has already accepted, and never in the same cycle as the acceptance. They also assume `rsp_valid` is low, not unknown, from reset onward. The bench's engine model keeps to this contract. It grants `cmd_ready` on an irregular pattern, so that commands stall. It answers every accepted command exactly two cycles after acceptance, and it refuses a chosen number of address bytes before it acknowledges one. The requests that the bench sends while the poller is busy carry a different address. If such a request were taken, the stream of commands would show it.

// File: rtl/ack_poll_seq.sv
module ack_poll_seq #(
  parameter int MAX_POLLS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_start,
  input  logic [6:0] tgt_addr,
  input  logic       hold_bus,
  output logic       busy,
  output logic       done,
  output logic       timeout,
  output logic       cmd_valid,
  input  logic       cmd_ready,
  output logic [1:0] cmd_op,
  output logic [7:0] cmd_byte,
  input  logic       rsp_valid,
  input  logic       rsp_ack
);
  localparam int CW = $clog2(MAX_POLLS + 1);
  localparam logic [1:0] OP_NONE  = 2'b00;
  localparam logic [1:0] OP_START = 2'b01;
  localparam logic [1:0] OP_WRITE = 2'b10;
  localparam logic [1:0] OP_STOP  = 2'b11;

  typedef enum logic [2:0] {
    IDLE, ST_ISSUE, ST_WAIT, BY_ISSUE, BY_WAIT, SP_ISSUE, SP_WAIT
  } state_t;
  typedef enum logic [1:0] {AFTER_RETRY, AFTER_DONE, AFTER_TOUT} after_t;

  state_t        state;
  after_t        after_stop;
  logic [6:0]    addr_q;
  logic          hold_q;
  logic [CW-1:0] polls;

  assign busy      = (state != IDLE);
  assign cmd_valid = (state == ST_ISSUE) || (state == BY_ISSUE) || (state == SP_ISSUE);
  assign cmd_op    = (state == ST_ISSUE) ? OP_START :
                     (state == BY_ISSUE) ? OP_WRITE :
                     (state == SP_ISSUE) ? OP_STOP  : OP_NONE;
  assign cmd_byte  = {addr_q, 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= IDLE;
      after_stop <= AFTER_RETRY;
      addr_q     <= '0;
      hold_q     <= 1'b0;
      polls      <= '0;
      done       <= 1'b0;
      timeout    <= 1'b0;
    end else begin
      done    <= 1'b0;
      timeout <= 1'b0;
      case (state)
        IDLE: if (req_start) begin
          addr_q <= tgt_addr;
          hold_q <= hold_bus;
          polls  <= '0;
          state  <= ST_ISSUE;
        end
        ST_ISSUE: if (cmd_ready) state <= ST_WAIT;
        ST_WAIT:  if (rsp_valid) state <= BY_ISSUE;
        BY_ISSUE: if (cmd_ready) state <= BY_WAIT;
        BY_WAIT: if (rsp_valid) begin
          if (rsp_ack) begin
            if (hold_q) begin
              done  <= 1'b1;
              state <= IDLE;
            end else begin
              after_stop <= AFTER_DONE;
              state      <= SP_ISSUE;
            end
          end else begin
            polls      <= polls + 1'b1;
            after_stop <= (polls + 1'b1 == CW'(MAX_POLLS)) ? AFTER_TOUT : AFTER_RETRY;
            state      <= SP_ISSUE;
          end
        end
        SP_ISSUE: if (cmd_ready) state <= SP_WAIT;
        SP_WAIT: if (rsp_valid) begin
          case (after_stop)
            AFTER_DONE:  begin done    <= 1'b1; state <= IDLE; end
            AFTER_TOUT:  begin timeout <= 1'b1; state <= IDLE; end
            default:     state <= ST_ISSUE;
          endcase
        end
        default: state <= IDLE;
      endcase
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!cmd_valid && cmd_op == OP_NONE));

  assert_prompt_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_start && !busy) |=> (cmd_valid && cmd_op == OP_START));

  assert_hold_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_byte)));

  assert_flag_after_rsp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done || timeout) |-> $past(rsp_valid));

  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout));

  assert_poll_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    polls <= CW'(MAX_POLLS));

  assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_start && cmd_valid && !cmd_ready) |=> $stable(cmd_byte));
endmodule

// File: tb/ack_poll_seq_tb.sv
module ack_poll_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAXP = 8;

  logic clk = 0, rst_n = 0;
  logic req_start = 0, hold_bus = 0;
  logic [6:0] tgt_addr = '0;
  logic busy, done, timeout, cmd_valid;
  logic cmd_ready = 0, rsp_valid = 0, rsp_ack = 0;
  logic [1:0] cmd_op;
  logic [7:0] cmd_byte;

  int checks = 0, fails = 0;
  int cyc = 0;
  int last_rsp_cyc = 0;
  int nacks_left = 0;
  int rsp_cnt = 0;
  logic pend_ack = 0;
  logic [9:0] exp_q[$];

  ack_poll_seq #(.MAX_POLLS(MAXP)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .tgt_addr(tgt_addr),
    .hold_bus(hold_bus), .busy(busy), .done(done), .timeout(timeout),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_byte(cmd_byte), .rsp_valid(rsp_valid), .rsp_ack(rsp_ack)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // byte-engine model and scoreboard monitor
  always @(negedge clk) begin
    rsp_valid = 0;
    if (rsp_cnt > 0) begin
      rsp_cnt--;
      if (rsp_cnt == 0) begin
        rsp_valid = 1;
        rsp_ack = pend_ack;
        last_rsp_cyc = cyc;
      end
    end
    cmd_ready = cmd_valid && rsp_cnt == 0 && !rsp_valid && ((cyc % 3) != 1);
    if (cmd_valid && cmd_ready) begin
      if (exp_q.size() == 0) begin
        check(0, "R2/R4 unexpected command", {cmd_op, cmd_byte}, 0);
      end else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        check({cmd_op, (cmd_op == 2'b10) ? cmd_byte : 8'h00} == e,
              "R2/R4/R8 command stream", {cmd_op, cmd_byte}, e);
      end
      pend_ack = 1;
      if (cmd_op == 2'b10) begin
        if (nacks_left > 0) begin pend_ack = 0; nacks_left--; end
      end
      rsp_cnt = 2;
    end
  end

  task automatic push_probe(input logic [6:0] a, input bit stop);
    exp_q.push_back({2'b01, 8'h00});
    exp_q.push_back({2'b10, a, 1'b0});
    if (stop) exp_q.push_back({2'b11, 8'h00});
  endtask

  task automatic run_poll(input logic [6:0] a, input bit hold, input int nacks,
                          input bit poke, input bit expect_tout);
    int refused;
    refused = (nacks < MAXP) ? nacks : MAXP;
    for (int i = 0; i < refused; i++) push_probe(a, 1);
    if (!expect_tout) push_probe(a, !hold);
    nacks_left = nacks;
    tgt_addr = a; hold_bus = hold; req_start = 1;
    @(negedge clk);
    req_start = 0; tgt_addr = 7'h7F; hold_bus = !hold;
    check(cmd_valid && cmd_op == 2'b01, "R3 immediate start", {cmd_valid, cmd_op}, 3'b101);
    for (int k = 0; k < 2000 && !(done || timeout); k++) begin
      if (poke && k == 3) begin
        check(busy, "R9 busy during poll", busy, 1);
        req_start = 1; tgt_addr = 7'h6C;
      end else begin
        req_start = 0;
      end
      @(negedge clk);
    end
    req_start = 0;
    if (expect_tout) begin
      check(timeout && !done, "R7 timeout flag", {done, timeout}, 2'b01);
    end else begin
      check(done && !timeout, hold ? "R6 done flag" : "R5 done flag", {done, timeout}, 2'b10);
    end
    check(cyc == last_rsp_cyc + 1, hold ? "R6 flag timing" : (expect_tout ? "R7 flag timing" : "R5 flag timing"),
          cyc, last_rsp_cyc + 1);
    check(exp_q.size() == 0, "R4 all expected commands seen", exp_q.size(), 0);
    exp_q.delete();
    @(negedge clk);
    check(!done && !timeout && !busy, "R5 R7 single pulse and idle", {done, timeout, busy}, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !timeout && !cmd_valid && cmd_op == 2'b00, "R1 reset state",
          {busy, done, timeout, cmd_valid, cmd_op}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !cmd_valid, "R1 idle after reset", {busy, cmd_valid}, 0);
    run_poll(7'h50, 0, 0, 0, 0);
    run_poll(7'h51, 0, 3, 0, 0);
    run_poll(7'h2A, 1, 2, 0, 0);
    run_poll(7'h13, 0, 4, 1, 0);
    run_poll(7'h44, 0, 50, 0, 1);
    run_poll(7'h44, 0, MAXP - 1, 0, 0);
    run_poll(7'h01, 1, 0, 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule